// File: doc/BRIEF.md
# Aligned SPI Transfer Chunk Planner

This block sits on the master side of a serial memory port whose slave accepts three transfer kinds: a 2-byte access, a 4-byte access and a burst of any multiple of 8 bytes up to a fixed cap. A request gives a start address, a byte count and a direction. The planner cuts the request into a series of transfer descriptors. Each descriptor carries an opcode, an address and a byte count. Every descriptor address is naturally aligned for its transfer kind, and the greedy choice at each step keeps the number of transfers small.

Requests enter through a valid/ready pair that is ready only while the planner is idle. Descriptors leave one per handshake on a second valid/ready pair. The downstream serial engine does the shifting and moves the data. Rejected requests raise a one-cycle error pulse. A completed request raises a one-cycle done pulse.

Top module: `spi_chunk_planner`

## Requirements
- R1: The descriptor opcode is {kind, write}. The kind is 0 for the 2-byte transfer, 1 for the 4-byte transfer and 2 for a burst. This gives read opcodes 0, 2 and 4, and write opcodes 1, 3 and 5.
- R2: When the current address modulo 8 is 2 or 6, or when exactly 2 bytes remain, the descriptor is a 2-byte transfer of length 2.
- R3: When R2 does not apply, and either the address modulo 8 is 4 or at most 6 bytes remain, the descriptor is a 4-byte transfer of length 4.
- R4: In all other cases the descriptor is a burst. Its length is the remaining count rounded down to a multiple of 8, capped at BURST_MAX (default 240). A burst address is a multiple of 8.
- R5: After each descriptor handshake, the next descriptor's address is the previous address plus the previous length. The lengths of a request add up to its padded byte count.
- R6: A read with an odd start address or an odd length issues no descriptor. It raises err for one cycle, in the cycle after acceptance.
- R7: A write with an odd start address is rejected in the same way as R6. A write with an odd length is planned as one byte longer, and desc_pad is high on its last descriptor only.
- R8: A request of length 0 that is not rejected issues no descriptor. It raises done in the cycle after acceptance.
- R9: done is high for exactly the one cycle after the final descriptor handshake. req_ready is high exactly when no descriptor is pending.
- R10: While desc_valid is high and desc_ready is low, desc_valid and all descriptor fields hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Planner idle and accepting a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Start byte address |
| req_len | input | LW | Byte count |
| desc_valid | output | 1 | Descriptor offered |
| desc_ready | input | 1 | Descriptor taken by the serial engine |
| desc_op | output | 3 | Transfer opcode (R1) |
| desc_addr | output | AW | Aligned transfer address |
| desc_len | output | $clog2(BURST_MAX+1) | Bytes in this transfer |
| desc_pad | output | 1 | Last write chunk carries one zero pad byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle rejection pulse |

## Verification
A request can complete and the next one can be accepted in the same cycle. The done pulse of one request coincides with req_ready going high, so a request held on the input is taken while done is still asserted. The bench holds req_valid high through the final descriptor of a request. In that cycle it expects done and req_ready together. In the following cycle it expects the first descriptor of the queued request, with done low.

// File: rtl/spi_chunk_pkg.sv
package spi_chunk_pkg;

   typedef enum logic [1:0] {
      CK_HALF  = 2'd0,
      CK_WORD  = 2'd1,
      CK_BURST = 2'd2
   } chunk_kind_e;

   function automatic logic [2:0] make_op(input chunk_kind_e kind, input logic wr);
      return {kind, wr};
   endfunction

endpackage

// File: rtl/spi_req_check.sv
module spi_req_check #(
   parameter int AW = 32,
   parameter int LW = 16,
   localparam int CW = LW + 1
) (
   input  logic          write,
   input  logic [AW-1:0] addr,
   input  logic [LW-1:0] len,
   output logic          bad,
   output logic          pad,
   output logic [CW-1:0] padded_len
);

   logic addr_odd;
   logic len_odd;

   assign addr_odd = addr[0];
   assign len_odd  = len[0];

   always_comb begin
      bad        = addr_odd || (!write && len_odd);
      pad        = write && len_odd;
      padded_len = {1'b0, len} + CW'(pad);
   end

endmodule

// File: rtl/spi_chunk_select.sv
module spi_chunk_select
   import spi_chunk_pkg::*;
#(
   parameter int CW        = 17,
   parameter int BURST_MAX = 240,
   localparam int LENW     = $clog2(BURST_MAX + 1)
) (
   input  logic [2:0]      addr_lo,
   input  logic [CW-1:0]   remain,
   output chunk_kind_e     kind,
   output logic [LENW-1:0] len
);

   logic [CW-1:0]   burst_raw;
   logic [LENW-1:0] burst_len;

   assign burst_raw = {remain[CW-1:3], 3'b000};

   generate
      if ((CW < 31) && ((1 << CW) <= BURST_MAX)) begin : g_uncapped
         assign burst_len = LENW'(burst_raw);
      end else begin : g_capped
         assign burst_len = (burst_raw > CW'(BURST_MAX)) ? LENW'(BURST_MAX)
                                                         : LENW'(burst_raw);
      end
   endgenerate

   always_comb begin
      if (addr_lo == 3'd2 || addr_lo == 3'd6 || remain == CW'(2)) begin
         kind = CK_HALF;
         len  = LENW'(2);
      end else if (addr_lo == 3'd4 || remain <= CW'(6)) begin
         kind = CK_WORD;
         len  = LENW'(4);
      end else begin
         kind = CK_BURST;
         len  = burst_len;
      end
   end

endmodule

// File: rtl/spi_chunk_planner.sv
module spi_chunk_planner
   import spi_chunk_pkg::*;
#(
   parameter int AW        = 32,
   parameter int LW        = 16,
   parameter int BURST_MAX = 240,
   localparam int CW       = LW + 1,
   localparam int LENW     = $clog2(BURST_MAX + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            req_valid,
   output logic            req_ready,
   input  logic            req_write,
   input  logic [AW-1:0]   req_addr,
   input  logic [LW-1:0]   req_len,
   output logic            desc_valid,
   input  logic            desc_ready,
   output logic [2:0]      desc_op,
   output logic [AW-1:0]   desc_addr,
   output logic [LENW-1:0] desc_len,
   output logic            desc_pad,
   output logic            done,
   output logic            err
);

   generate
      if (BURST_MAX < 8 || (BURST_MAX % 8) != 0) begin : g_bad_burst
         $error("BURST_MAX must be a nonzero multiple of 8");
      end
      if (AW < 3) begin : g_bad_aw
         $error("AW must be at least 3");
      end
      if (LW < 3) begin : g_bad_lw
         $error("LW must be at least 3");
      end
   endgenerate

   logic            busy_q;
   logic            wr_q;
   logic            pad_q;
   logic            done_q;
   logic            err_q;
   logic [AW-1:0]   addr_q;
   logic [CW-1:0]   remain_q;

   logic            chk_bad;
   logic            chk_pad;
   logic [CW-1:0]   chk_len;
   chunk_kind_e     sel_kind;
   logic [LENW-1:0] sel_len;

   logic            accept;
   logic            fire;
   logic            last;

   spi_req_check #(.AW(AW), .LW(LW)) u_check (
      .write      (req_write),
      .addr       (req_addr),
      .len        (req_len),
      .bad        (chk_bad),
      .pad        (chk_pad),
      .padded_len (chk_len)
   );

   spi_chunk_select #(.CW(CW), .BURST_MAX(BURST_MAX)) u_select (
      .addr_lo (addr_q[2:0]),
      .remain  (remain_q),
      .kind    (sel_kind),
      .len     (sel_len)
   );

   assign accept = req_valid && !busy_q;
   assign fire   = busy_q && desc_ready;
   assign last   = (remain_q == CW'(sel_len));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         wr_q     <= 1'b0;
         pad_q    <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
         addr_q   <= '0;
         remain_q <= '0;
      end else begin
         done_q <= 1'b0;
         err_q  <= 1'b0;
         if (accept) begin
            if (chk_bad) begin
               err_q <= 1'b1;
            end else if (chk_len == '0) begin
               done_q <= 1'b1;
            end else begin
               busy_q   <= 1'b1;
               wr_q     <= req_write;
               pad_q    <= chk_pad;
               addr_q   <= req_addr;
               remain_q <= chk_len;
            end
         end
         if (fire) begin
            addr_q   <= addr_q + AW'(sel_len);
            remain_q <= remain_q - CW'(sel_len);
            if (last) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
            end
         end
      end
   end

   assign req_ready  = !busy_q;
   assign desc_valid = busy_q;
   assign desc_op    = make_op(sel_kind, wr_q);
   assign desc_addr  = addr_q;
   assign desc_len   = sel_len;
   assign desc_pad   = busy_q && wr_q && pad_q && last;
   assign done       = done_q;
   assign err        = err_q;

endmodule

// File: rtl/spi_chunk_planner_chk.sv
module spi_chunk_planner_chk #(
   parameter int AW        = 32,
   parameter int BURST_MAX = 240,
   localparam int LENW     = $clog2(BURST_MAX + 1)
) (
   input logic            clk,
   input logic            rst_n,
   input logic            req_ready,
   input logic            desc_valid,
   input logic            desc_ready,
   input logic [2:0]      desc_op,
   input logic [AW-1:0]   desc_addr,
   input logic [LENW-1:0] desc_len,
   input logic            desc_pad,
   input logic            done,
   input logic            err
);

   AST_OP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> desc_op <= 3'd5); // R1

   AST_HALF_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_op[2:1] == 2'd0) |-> (desc_len == LENW'(2) && desc_addr[0] == 1'b0)); // R2

   AST_WORD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_op[2:1] == 2'd1) |-> (desc_len == LENW'(4) && desc_addr[1:0] == 2'b00)); // R3

   AST_BURST_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_op[2:1] == 2'd2) |->
         (desc_len[2:0] == 3'b000 && desc_len >= LENW'(8) && desc_len <= LENW'(BURST_MAX)
          && desc_addr[2:0] == 3'b000)); // R4

   AST_ADDR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && desc_ready) |=>
         (!desc_valid || desc_addr == $past(desc_addr) + AW'($past(desc_len)))); // R5

   AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!desc_valid && !done)); // R6

   AST_PAD_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      desc_pad |-> (desc_valid && desc_op[0])); // R7

   AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!desc_valid && req_ready)); // R9

   AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> !req_ready); // R9

   AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (desc_valid && !desc_ready) |=>
         (desc_valid && $stable(desc_op) && $stable(desc_addr) && $stable(desc_len)
          && $stable(desc_pad))); // R10

endmodule

bind spi_chunk_planner spi_chunk_planner_chk #(.AW(AW), .BURST_MAX(BURST_MAX)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_ready  (req_ready),
   .desc_valid (desc_valid),
   .desc_ready (desc_ready),
   .desc_op    (desc_op),
   .desc_addr  (desc_addr),
   .desc_len   (desc_len),
   .desc_pad   (desc_pad),
   .done       (done),
   .err        (err)
);

// File: tb/tb_spi_chunk_planner.sv
module tb_spi_chunk_planner;

   localparam int AW = 32;
   localparam int LW = 16;
   localparam int NV = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [31:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic        desc_valid;
   logic        desc_ready = 1'b1;
   logic [2:0]  desc_op;
   logic [31:0] desc_addr;
   logic [7:0]  desc_len;
   logic        desc_pad;
   logic        done;
   logic        err;

   int checks = 0;
   int fails  = 0;

   always #2.5 clk = ~clk;

   spi_chunk_planner #(.AW(AW), .LW(LW), .BURST_MAX(240)) dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
      .desc_valid(desc_valid), .desc_ready(desc_ready), .desc_op(desc_op),
      .desc_addr(desc_addr), .desc_len(desc_len), .desc_pad(desc_pad),
      .done(done), .err(err)
   );

   // Vector table: direction, start address, length, expected chunk count,
   // expected chunk lengths (first chunk in the low byte), pad expected.
   localparam logic        V_WR  [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};
   localparam logic [31:0] V_AD  [NV] = '{32'h6003_0002, 32'h100, 32'h4, 32'h6,
                                          32'h0, 32'h8, 32'h0, 32'h2};
   localparam logic [15:0] V_LN  [NV] = '{16'd260, 16'd16, 16'd6, 16'd7,
                                          16'd500, 16'd2, 16'd10, 16'd12};
   localparam int          V_CNT [NV] = '{6, 1, 2, 3, 4, 1, 2, 4};
   localparam logic [63:0] V_LS  [NV] = '{64'h0000_0204_08F0_0402, 64'h10, 64'h0204,
                                          64'h02_0402, 64'h0410_F0F0, 64'h02,
                                          64'h0208, 64'h0204_0402};
   localparam logic        V_PAD [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0};

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [2:0] exp_op(input int len, input logic wr);
      logic [1:0] k;
      k = (len == 2) ? 2'd0 : (len == 4) ? 2'd1 : 2'd2;
      return {k, wr};
   endfunction

   task automatic send(input logic wr, input logic [31:0] a, input logic [15:0] l);
      @(negedge clk);
      req_write = wr;
      req_addr  = a;
      req_len   = l;
      req_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Drains a planned request with desc_ready high and checks every chunk.
   task automatic drain(input logic wr, input logic [31:0] a, input int cnt,
                        input logic [63:0] lens, input logic pad);
      logic [31:0] ea;
      int n;
      ea = a;
      n  = 0;
      desc_ready = 1'b1;
      for (int g = 0; g < 400; g++) begin
         if (!desc_valid) break;
         if (n < 8) begin
            check(desc_len == lens[8*n +: 8], "R2/R3/R4 len", desc_len, lens[8*n +: 8]);
            check(desc_op == exp_op(int'(lens[8*n +: 8]), wr), "R1 op", desc_op,
                  exp_op(int'(lens[8*n +: 8]), wr));
            check(desc_addr == ea, "R5 addr", desc_addr, ea);
            check(desc_pad == (pad && n == cnt - 1), "R7 pad", desc_pad, pad && n == cnt - 1);
            check(!req_ready, "R9 ready while busy", req_ready, 0);
            ea = ea + 32'(lens[8*n +: 8]);
         end
         n++;
         @(negedge clk);
      end
      check(n == cnt, "R5 chunk count", n, cnt);
      check(done == 1'b1, "R9 done after last", done, 1);
      @(negedge clk);
      check(done == 1'b0, "R9 done one cycle", done, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(req_ready == 1'b1 && desc_valid == 1'b0 && done == 1'b0 && err == 1'b0,
            "R9 reset state", {req_ready, desc_valid, done, err}, 4'b1000);
      rst_n = 1'b1;
      @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         send(V_WR[v], V_AD[v], V_LN[v]);
         drain(V_WR[v], V_AD[v], V_CNT[v], V_LS[v], V_PAD[v]);
      end

      // R6: odd read address, odd read length
      send(1'b0, 32'h3, 16'd8);
      check(err && !desc_valid && !done, "R6 odd read addr", {err, desc_valid, done}, 3'b100);
      @(negedge clk);
      check(!err && !desc_valid, "R6 no descriptor", {err, desc_valid}, 2'b00);
      send(1'b0, 32'h10, 16'd5);
      check(err && !desc_valid, "R6 odd read len", {err, desc_valid}, 2'b10);
      @(negedge clk);

      // R7: odd write address rejected
      send(1'b1, 32'h21, 16'd4);
      check(err && !desc_valid, "R7 odd write addr", {err, desc_valid}, 2'b10);
      @(negedge clk);

      // R8: zero length
      send(1'b0, 32'h40, 16'd0);
      check(done && !err && !desc_valid, "R8 zero length", {done, err, desc_valid}, 3'b100);
      @(negedge clk);
      check(!desc_valid && !done, "R8 no descriptor", {desc_valid, done}, 2'b00);

      // R10: back-pressure on 260 bytes at 0 -> 240, 16, 4
      desc_ready = 1'b0;
      send(1'b0, 32'h0, 16'd260);
      for (int h = 0; h < 3; h++) begin
         @(negedge clk);
         check(desc_valid && desc_addr == 32'h0 && desc_len == 8'd240 && desc_op == 3'd4,
               "R10 hold", {desc_op, desc_len}, {3'd4, 8'd240});
      end
      drain(1'b0, 32'h0, 3, 64'h04_10F0, 1'b0);

      // R9: completion and acceptance of a queued request in the same cycle
      send(1'b1, 32'h8, 16'd2);
      req_write = 1'b0;
      req_addr  = 32'h10;
      req_len   = 16'd4;
      req_valid = 1'b1;
      check(desc_valid && desc_op == 3'd1 && desc_len == 8'd2, "R9 first request",
            {desc_op, desc_len}, {3'd1, 8'd2});
      @(negedge clk);
      check(done && req_ready, "R9 done with ready", {done, req_ready}, 2'b11);
      @(negedge clk);
      req_valid = 1'b0;
      check(desc_valid && !done && desc_addr == 32'h10 && desc_op == 3'd2 && desc_len == 8'd4,
            "R9 queued request taken", {desc_addr, desc_op}, {32'h10, 3'd2});
      drain(1'b0, 32'h10, 1, 64'h04, 1'b0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule